// File: doc/BRIEF.md
# Multithreaded Two-Read Two-Write Register File

This block is the floating-point register store shared by eight hardware threads. It holds 256 words of 78 bits, split into eight thread banks of 32 registers each. Two read ports and two write ports work in the same cycle. Each port names an entry by a 3-bit thread number and a 5-bit register number. A write port also carries the 78-bit value to store.

On a read, every thread bank looks up the requested register at the same time, and the thread number then picks one of the eight results. Write addresses go through two predecoders that run side by side, one for the thread field and one for the register field. Their one-hot outputs are ANDed to give one word-line out of 256.

A read may name an entry that a write port updates in the same cycle. In that case the write is performed and the read is dropped: the port returns zero and raises its conflict flag. If both write ports name one entry, write port 1 prevails and a collision flag is raised. A standby input freezes the whole array. All ports are plain per-cycle signals with no handshake, so the block never applies back-pressure and a request is accepted in the cycle it is presented.

Top module: `mtrf_2r2w`

## Requirements
- R1: The entry address is {tid[2:0], idx[4:0]}, giving 8 threads of 32 registers of 78 bits each. A value written to an entry is returned by a later read of that same entry.
- R2: Both write ports commit on the same rising edge when they name different entries.
- R3: Both read ports serve independent addresses in the same cycle, and the read data appears on the cycle after the request.
- R4: When a read enable is low, that port's data output is zero on the following cycle and its conflict flag is low.
- R5: When a read and an enabled write name the same entry in one cycle, the write commits. On the next cycle the read port outputs zero and its conflict flag is high.
- R6: When both write ports are enabled and name the same entry, the value from write port 1 is stored, and `wr_collide` is high on the next cycle.
- R7: While `standby` is high, reads and writes are ignored. On the following cycle the read data is zero and all flags are low. Stored contents are unchanged.
- R8: After reset, the read data outputs, both conflict flags and `wr_collide` are zero.
- R9: A conflict needs the full 8-bit address to match. The same register number in another thread neither conflicts nor is affected by the write.
- R10: A write port whose enable is low never causes a read conflict, even if its address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Freeze array, ignore all ports |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_tid | input | 3 | Read port 0 thread number |
| rd0_idx | input | 5 | Read port 0 register number |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_tid | input | 3 | Read port 1 thread number |
| rd1_idx | input | 5 | Read port 1 register number |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_tid | input | 3 | Write port 0 thread number |
| wr0_idx | input | 5 | Write port 0 register number |
| wr0_data | input | 78 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_tid | input | 3 | Write port 1 thread number |
| wr1_idx | input | 5 | Write port 1 register number |
| wr1_data | input | 78 | Write port 1 data |
| rd0_data | output | 78 | Read port 0 data, one cycle after request |
| rd0_conflict | output | 1 | Read port 0 was suppressed by a write |
| rd1_data | output | 78 | Read port 1 data, one cycle after request |
| rd1_conflict | output | 1 | Read port 1 was suppressed by a write |
| wr_collide | output | 1 | Both write ports hit one entry last cycle |

## Verification
A faulty word-line decode or a wrong thread select corrupts a stored entry. The error shows up only when that entry is read back, which can be many cycles after the bad write, so the bench first fills every entry and then keeps a shadow model checked on every read. Faults in address compare, write priority or standby gating show up one cycle after the stimulus, on the conflict flags, `wr_collide` or the zeroed read data. Random traffic is biased toward a few register numbers so that same-cycle collisions happen often.

// File: rtl/mtrf_pkg.sv
package mtrf_pkg;
  localparam int DEF_TID_W  = 3;
  localparam int DEF_IDX_W  = 5;
  localparam int DEF_DATA_W = 78;
  localparam int NUM_RD     = 2;
  localparam int NUM_WR     = 2;
endpackage

// File: rtl/mtrf_predecode.sv
// One-hot predecoder: a binary field becomes a one-hot line set, gated by enable.
module mtrf_predecode #(
  parameter int IN_W = 3
) (
  input  logic                  en,
  input  logic [IN_W-1:0]       sel,
  output logic [(1<<IN_W)-1:0]  onehot
);
  localparam int OUT_N = 1 << IN_W;

  always_comb begin
    for (int i = 0; i < OUT_N; i++) begin
      onehot[i] = en && (sel == IN_W'(i));
    end
  end
endmodule

// File: rtl/mtrf_thread_bank.sv
// One thread's register slice: per-entry word-line writes, two combinational lookups.
module mtrf_thread_bank #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 78
) (
  input  logic                  clk,
  input  logic [(1<<IDX_W)-1:0] line0,
  input  logic [(1<<IDX_W)-1:0] line1,
  input  logic [DATA_W-1:0]     wd0,
  input  logic [DATA_W-1:0]     wd1,
  input  logic [IDX_W-1:0]      ra0,
  input  logic [IDX_W-1:0]      ra1,
  output logic [DATA_W-1:0]     rd0,
  output logic [DATA_W-1:0]     rd1
);
  localparam int REGS = 1 << IDX_W;

  logic [DATA_W-1:0] cells [REGS];

  for (genvar e = 0; e < REGS; e++) begin : g_cell
    // write port 1 takes priority on a shared word line
    always_ff @(posedge clk) begin
      if (line1[e])      cells[e] <= wd1;
      else if (line0[e]) cells[e] <= wd0;
    end
  end

  assign rd0 = cells[ra0];
  assign rd1 = cells[ra1];
endmodule

// File: rtl/mtrf_addr_cmp.sv
// Compares one read address against every write port in the same cycle.
module mtrf_addr_cmp #(
  parameter int ADDR_W = 8,
  parameter int NWR    = 2
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NWR-1:0]    wr_en,
  input  logic [ADDR_W-1:0] wr_addr [NWR],
  output logic              hit
);
  always_comb begin
    hit = 1'b0;
    for (int w = 0; w < NWR; w++) begin
      if (rd_en && wr_en[w] && (wr_addr[w] == rd_addr)) hit = 1'b1;
    end
  end
endmodule

// File: rtl/mtrf_2r2w.sv
module mtrf_2r2w
  import mtrf_pkg::*;
#(
  parameter int TID_W  = DEF_TID_W,
  parameter int IDX_W  = DEF_IDX_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              rd0_en,
  input  logic [TID_W-1:0]  rd0_tid,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic              rd1_en,
  input  logic [TID_W-1:0]  rd1_tid,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic              wr0_en,
  input  logic [TID_W-1:0]  wr0_tid,
  input  logic [IDX_W-1:0]  wr0_idx,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [TID_W-1:0]  wr1_tid,
  input  logic [IDX_W-1:0]  wr1_idx,
  input  logic [DATA_W-1:0] wr1_data,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_conflict,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_conflict,
  output logic              wr_collide
);
  localparam int THREADS = 1 << TID_W;
  localparam int REGS    = 1 << IDX_W;
  localparam int ADDR_W  = TID_W + IDX_W;

  // ---- port gathering, standby gating ----
  logic [NUM_RD-1:0] rd_en_v;
  logic [TID_W-1:0]  rd_tid_v  [NUM_RD];
  logic [IDX_W-1:0]  rd_idx_v  [NUM_RD];
  logic [NUM_WR-1:0] wr_en_v;
  logic [TID_W-1:0]  wr_tid_v  [NUM_WR];
  logic [IDX_W-1:0]  wr_idx_v  [NUM_WR];
  logic [DATA_W-1:0] wr_data_v [NUM_WR];
  logic [ADDR_W-1:0] wr_addr_v [NUM_WR];

  assign rd_en_v     = {rd1_en, rd0_en} & {NUM_RD{~standby}};
  assign rd_tid_v[0] = rd0_tid;
  assign rd_tid_v[1] = rd1_tid;
  assign rd_idx_v[0] = rd0_idx;
  assign rd_idx_v[1] = rd1_idx;

  assign wr_en_v      = {wr1_en, wr0_en} & {NUM_WR{~standby}};
  assign wr_tid_v[0]  = wr0_tid;
  assign wr_tid_v[1]  = wr1_tid;
  assign wr_idx_v[0]  = wr0_idx;
  assign wr_idx_v[1]  = wr1_idx;
  assign wr_data_v[0] = wr0_data;
  assign wr_data_v[1] = wr1_data;

  // ---- two parallel predecode stages per write port ----
  logic [THREADS-1:0] tid_oh [NUM_WR];
  logic [REGS-1:0]    idx_oh [NUM_WR];

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wdec
    assign wr_addr_v[w] = {wr_tid_v[w], wr_idx_v[w]};

    mtrf_predecode #(.IN_W(TID_W)) u_tid_dec (
      .en     (wr_en_v[w]),
      .sel    (wr_tid_v[w]),
      .onehot (tid_oh[w])
    );
    mtrf_predecode #(.IN_W(IDX_W)) u_idx_dec (
      .en     (1'b1),
      .sel    (wr_idx_v[w]),
      .onehot (idx_oh[w])
    );
  end

  // ---- thread banks: final AND of predecodes, parallel fetch ----
  logic [DATA_W-1:0] fetch [NUM_RD][THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_bank
    logic [REGS-1:0] line0;
    logic [REGS-1:0] line1;
    assign line0 = tid_oh[0][t] ? idx_oh[0] : '0;
    assign line1 = tid_oh[1][t] ? idx_oh[1] : '0;

    mtrf_thread_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .line0 (line0),
      .line1 (line1),
      .wd0   (wr_data_v[0]),
      .wd1   (wr_data_v[1]),
      .ra0   (rd_idx_v[0]),
      .ra1   (rd_idx_v[1]),
      .rd0   (fetch[0][t]),
      .rd1   (fetch[1][t])
    );
  end

  // ---- per read port: compare, late thread select, output register ----
  logic [NUM_RD-1:0] rd_hit;
  logic [NUM_RD-1:0] conf_q;
  logic [DATA_W-1:0] data_q [NUM_RD];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
    logic [DATA_W-1:0] picked;

    mtrf_addr_cmp #(.ADDR_W(ADDR_W), .NWR(NUM_WR)) u_cmp (
      .rd_en   (rd_en_v[p]),
      .rd_addr ({rd_tid_v[p], rd_idx_v[p]}),
      .wr_en   (wr_en_v),
      .wr_addr (wr_addr_v),
      .hit     (rd_hit[p])
    );

    assign picked = fetch[p][rd_tid_v[p]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        conf_q[p] <= 1'b0;
        data_q[p] <= '0;
      end else begin
        conf_q[p] <= rd_en_v[p] & rd_hit[p];
        data_q[p] <= (rd_en_v[p] && !rd_hit[p]) ? picked : '0;
      end
    end
  end

  // ---- write/write collision status ----
  logic ww_same;
  logic collide_q;
  assign ww_same = (&wr_en_v) && (wr_addr_v[0] == wr_addr_v[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= ww_same;
  end

  assign rd0_data     = data_q[0];
  assign rd1_data     = data_q[1];
  assign rd0_conflict = conf_q[0];
  assign rd1_conflict = conf_q[1];
  assign wr_collide   = collide_q;
endmodule

// File: rtl/mtrf_checker.sv
module mtrf_checker #(
  parameter int TID_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 78
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              rd0_en,
  input logic              rd1_en,
  input logic              wr0_en,
  input logic [TID_W-1:0]  wr0_tid,
  input logic [IDX_W-1:0]  wr0_idx,
  input logic              wr1_en,
  input logic [TID_W-1:0]  wr1_tid,
  input logic [IDX_W-1:0]  wr1_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic              rd0_conflict,
  input logic [DATA_W-1:0] rd1_data,
  input logic              rd1_conflict,
  input logic              wr_collide
);
  a_r5_rd0_conflict_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_conflict |-> (rd0_data == '0));

  a_r5_rd1_conflict_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_conflict |-> (rd1_data == '0));

  a_r6_collide_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |-> $past(wr0_en && wr1_en && !standby &&
                         ({wr0_tid, wr0_idx} == {wr1_tid, wr1_idx})));

  a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(standby) |-> (rd0_data == '0 && rd1_data == '0 &&
                        !rd0_conflict && !rd1_conflict && !wr_collide));

  a_r4_idle_rd0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd0_en) |-> (rd0_data == '0 && !rd0_conflict));

  a_r4_idle_rd1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd1_en) |-> (rd1_data == '0 && !rd1_conflict));
endmodule

bind mtrf_2r2w mtrf_checker #(.TID_W(TID_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .rd0_en(rd0_en), .rd1_en(rd1_en),
  .wr0_en(wr0_en), .wr0_tid(wr0_tid), .wr0_idx(wr0_idx),
  .wr1_en(wr1_en), .wr1_tid(wr1_tid), .wr1_idx(wr1_idx),
  .rd0_data(rd0_data), .rd0_conflict(rd0_conflict),
  .rd1_data(rd1_data), .rd1_conflict(rd1_conflict),
  .wr_collide(wr_collide)
);

// File: tb/mtrf_2r2w_tb.sv
module mtrf_2r2w_tb;
  localparam int DW = 78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0;
  logic rd0_en = 0, rd1_en = 0, wr0_en = 0, wr1_en = 0;
  logic [2:0] rd0_tid = 0, rd1_tid = 0, wr0_tid = 0, wr1_tid = 0;
  logic [4:0] rd0_idx = 0, rd1_idx = 0, wr0_idx = 0, wr1_idx = 0;
  logic [DW-1:0] wr0_data = '0, wr1_data = '0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic rd0_conflict, rd1_conflict, wr_collide;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] model [256];

  always #10 clk = ~clk;

  mtrf_2r2w u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .rd0_en(rd0_en), .rd0_tid(rd0_tid), .rd0_idx(rd0_idx),
    .rd1_en(rd1_en), .rd1_tid(rd1_tid), .rd1_idx(rd1_idx),
    .wr0_en(wr0_en), .wr0_tid(wr0_tid), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_tid(wr1_tid), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .rd0_data(rd0_data), .rd0_conflict(rd0_conflict),
    .rd1_data(rd1_data), .rd1_conflict(rd1_conflict),
    .wr_collide(wr_collide)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom, $urandom, $urandom};
  endfunction

  // Expected outputs one cycle later, from the current inputs and the model.
  task automatic step(input string req);
    logic [7:0] a0, a1, w0, w1;
    logic c0, c1, col;
    logic [DW-1:0] e0, e1;
    a0 = {rd0_tid, rd0_idx};
    a1 = {rd1_tid, rd1_idx};
    w0 = {wr0_tid, wr0_idx};
    w1 = {wr1_tid, wr1_idx};
    c0 = !standby && rd0_en && ((wr0_en && w0 == a0) || (wr1_en && w1 == a0));
    c1 = !standby && rd1_en && ((wr0_en && w0 == a1) || (wr1_en && w1 == a1));
    col = !standby && wr0_en && wr1_en && (w0 == w1);
    e0 = (!standby && rd0_en && !c0) ? model[a0] : '0;
    e1 = (!standby && rd1_en && !c1) ? model[a1] : '0;
    if (!standby) begin
      if (wr0_en) model[w0] = wr0_data;
      if (wr1_en) model[w1] = wr1_data;
    end
    @(negedge clk);
    check(rd0_data === e0, req, "rd0_data", rd0_data, e0);
    check(rd1_data === e1, req, "rd1_data", rd1_data, e1);
    check(rd0_conflict === c0, req, "rd0_conflict", DW'(rd0_conflict), DW'(c0));
    check(rd1_conflict === c1, req, "rd1_conflict", DW'(rd1_conflict), DW'(c1));
    check(wr_collide === col, req, "wr_collide", DW'(wr_collide), DW'(col));
  endtask

  task automatic idle();
    standby = 0; rd0_en = 0; rd1_en = 0; wr0_en = 0; wr1_en = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R8: reset state
    check(rd0_data === '0 && rd1_data === '0, "R8", "rd data in reset", rd0_data | rd1_data, '0);
    check(!rd0_conflict && !rd1_conflict && !wr_collide, "R8", "flags in reset",
          DW'({rd0_conflict, rd1_conflict, wr_collide}), '0);
    rst_n = 1;
    @(negedge clk);
    check(rd0_data === '0 && !rd0_conflict && !wr_collide, "R8", "after release",
          rd0_data, '0);

    // R2: fill all 256 entries two at a time
    for (int a = 0; a < 256; a += 2) begin
      wr0_en = 1; {wr0_tid, wr0_idx} = 8'(a);     wr0_data = rnd_data();
      wr1_en = 1; {wr1_tid, wr1_idx} = 8'(a + 1); wr1_data = rnd_data();
      step("R2");
    end
    idle();

    // R1/R3: read back everything on both ports
    for (int a = 0; a < 256; a += 2) begin
      rd0_en = 1; {rd0_tid, rd0_idx} = 8'(a);
      rd1_en = 1; {rd1_tid, rd1_idx} = 8'(255 - a);
      step("R1_R3");
    end
    idle();
    step("R4");

    // R5: read and write same entry
    rd0_en = 1; rd0_tid = 3; rd0_idx = 7;
    wr0_en = 1; wr0_tid = 3; wr0_idx = 7; wr0_data = rnd_data();
    step("R5");
    idle(); rd0_en = 1; rd0_tid = 3; rd0_idx = 7;
    step("R5");

    // R9: same register number in another thread, no conflict
    rd1_en = 1; rd1_tid = 2; rd1_idx = 9;
    wr1_en = 1; wr1_tid = 5; wr1_idx = 9; wr1_data = rnd_data();
    step("R9");
    idle(); rd0_en = 1; rd0_tid = 2; rd0_idx = 9; rd1_en = 1; rd1_tid = 5; rd1_idx = 9;
    step("R9");

    // R10: matching address but write disabled
    idle(); rd0_en = 1; rd0_tid = 1; rd0_idx = 1; wr0_tid = 1; wr0_idx = 1;
    wr1_tid = 1; wr1_idx = 1;
    step("R10");

    // R6: write-write collision, port 1 wins
    idle();
    wr0_en = 1; wr0_tid = 6; wr0_idx = 30; wr0_data = rnd_data();
    wr1_en = 1; wr1_tid = 6; wr1_idx = 30; wr1_data = rnd_data();
    step("R6");
    idle(); rd1_en = 1; rd1_tid = 6; rd1_idx = 30;
    step("R6");

    // R7: standby ignores everything, keeps contents
    standby = 1; rd0_en = 1; rd0_tid = 6; rd0_idx = 30;
    wr0_en = 1; wr0_tid = 6; wr0_idx = 30; wr0_data = rnd_data();
    wr1_en = 1; wr1_tid = 6; wr1_idx = 30; wr1_data = rnd_data();
    step("R7");
    idle(); rd0_en = 1; rd0_tid = 6; rd0_idx = 30;
    step("R7");

    // random traffic biased toward a few registers
    for (int n = 0; n < 3000; n++) begin
      standby = ($urandom_range(0, 19) == 0);
      rd0_en = $urandom_range(0, 1); rd1_en = $urandom_range(0, 1);
      wr0_en = $urandom_range(0, 1); wr1_en = $urandom_range(0, 1);
      rd0_tid = 3'($urandom_range(0, 1)); rd1_tid = 3'($urandom_range(0, 7));
      wr0_tid = 3'($urandom_range(0, 1)); wr1_tid = 3'($urandom_range(0, 7));
      rd0_idx = 5'($urandom_range(0, 3)); rd1_idx = 5'($urandom_range(0, 31));
      wr0_idx = 5'($urandom_range(0, 3)); wr1_idx = 5'($urandom_range(0, 3));
      wr0_data = rnd_data(); wr1_data = rnd_data();
      step("R1_R5_R6_R7_random");
    end
    idle();
    step("R4");

    done = 1;
    summary();
    $finish;
  end
endmodule